// File: doc/BRIEF.md
# Peripheral Write Width Adapter

This block sits between a processor's store port and a region of memory-mapped peripherals. Each accepted store names an address, an access size of 8, 16, 32, 64 or 128 bits, and right-justified write data. The block turns the store into the one native access its target understands. Stores to a 128-bit FIFO port become a single zero-filled 128-bit push. Stores to the true 64-bit register page become 64-bit register writes. Stores to ordinary registers become 32-bit writes, with the upper bits dropped. Stores to the byte-wide serial transmit port become a stream of byte strobes.

Byte and halfword stores to ordinary registers cannot be written in place. The block fetches the aligned word over a read port, patches the addressed byte or halfword into it, and writes the merged word back. While such a merge or a serial byte stream is in progress, the block raises `busy` and ignores new requests. A store whose address is not a multiple of its size is refused and reported on `err`.

Top module: `bwa_write_adapter`

## Requirements
- R1: `req_size` encodes the access size as 0=8, 1=16, 2=32, 3=64 and 4=128 bits. Data is taken from the low bits of `req_wdata`. Pages are `req_addr[15:12]`, and pages 4 to 7 are FIFO ports 0 to 3. A 128-bit store to a FIFO page gives one push, one cycle after acceptance, with `fifo_port` = page-4 and the full data.
- R2: A 32-bit store to a FIFO page pushes the data in 32-bit lane `req_addr[3:2]`, and all other lanes are zero.
- R3: A 64-bit store to a FIFO page pushes the data in 64-bit half `req_addr[3]`, and the other half is zero. An 8-bit or 16-bit store is likewise zero-filled, with the data placed at byte offset `req_addr[3:0]`.
- R4: Page 7 is a shared input/output port. With `req_addr[4]` = 1 a store pushes to port 3. With `req_addr[4]` = 0 it is dropped, and no output of any kind fires.
- R5: On page 2, a 64-bit store writes all 64 bits through `reg64_wr` at the 8-aligned address. A 128-bit store writes only its low 64 bits there. A 32-bit store is a plain register write.
- R6: On an ordinary register page (any page other than 2 and 4 to 7), a 32-bit, 64-bit or 128-bit store becomes one `reg_wr` of the low 32 bits at the store address, one cycle after acceptance.
- R7: An 8-bit or 16-bit store to a register page raises `rd_req` with the word-aligned `rd_addr` in the cycle after acceptance, and samples `rd_data` in that cycle. In the next cycle it pulses `reg_wr` with that word, in which the addressed byte (offset `req_addr[1:0]`) or halfword (`req_addr[1]`) has been replaced.
- R8: `busy` is high in the read cycle of a merge. A request presented while `busy` is high is ignored and produces no output.
- R9: Stores whose word address equals 0xF180 go to the serial transmit port. A 32-bit, 64-bit or 128-bit store emits the four low bytes, least significant byte first. A 16-bit store emits two bytes and an 8-bit store emits one. There is one `tx_wr` byte per cycle from the cycle after acceptance, and `busy` stays high while bytes remain.
- R10: A store whose address is not a multiple of its size, or whose size code is above 4, pulses `err` for one cycle after acceptance and performs nothing.
- R11: After reset every strobe and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_addr | input | 16 | Byte address of the store |
| req_size | input | 3 | Size code, 0=8 to 4=128 bits |
| req_wdata | input | 128 | Right-justified store data |
| busy | output | 1 | Merge read or serial stream in progress; requests ignored |
| err | output | 1 | Misaligned or illegal store refused |
| fifo_push | output | 1 | 128-bit FIFO push strobe |
| fifo_port | output | 2 | Selected FIFO port |
| fifo_data | output | 128 | Zero-filled push beat |
| reg_wr | output | 1 | 32-bit register write strobe |
| reg_addr | output | 16 | Register write address |
| reg_wdata | output | 32 | Register write data |
| reg64_wr | output | 1 | 64-bit register write strobe |
| reg64_addr | output | 16 | 64-bit register address |
| reg64_wdata | output | 64 | 64-bit register data |
| rd_req | output | 1 | Merge read strobe |
| rd_addr | output | 16 | Word-aligned merge read address |
| rd_data | input | 32 | Read word, valid while rd_req is high |
| tx_wr | output | 1 | Serial byte strobe |
| tx_byte | output | 8 | Serial byte |

## Verification
Direct pushes, register writes, 64-bit writes and `err` are due in the cycle after the accepting edge. A merge shows its read strobe in that cycle and its register write one cycle later. A serial store shows its bytes in consecutive cycles, starting from that same cycle. The bench applies every request at a falling edge, lets one rising edge accept it, and reads the outputs at the following falling edges, one edge per pipeline step. Every sample also checks that no unexpected strobe is active. Busy behaviour is covered by holding a competing request during a merge and during a byte stream, then confirming that it leaves no trace.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [2:0] {
    SZ_8   = 3'd0,
    SZ_16  = 3'd1,
    SZ_32  = 3'd2,
    SZ_64  = 3'd3,
    SZ_128 = 3'd4
  } size_e;

  typedef enum logic [2:0] {
    RG_REG32,
    RG_REG64,
    RG_FIFO,
    RG_FIFO_DROP,
    RG_TX
  } region_e;

  // number of bytes moved by a size code (0 for illegal codes)
  function automatic logic [4:0] size_bytes(input logic [2:0] sz);
    case (sz)
      SZ_8:    return 5'd1;
      SZ_16:   return 5'd2;
      SZ_32:   return 5'd4;
      SZ_64:   return 5'd8;
      SZ_128:  return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  // true when the low address bits break the natural alignment of the size
  function automatic logic misaligned(input logic [3:0] lo, input logic [2:0] sz);
    case (sz)
      SZ_8:    return 1'b0;
      SZ_16:   return lo[0];
      SZ_32:   return |lo[1:0];
      SZ_64:   return |lo[2:0];
      SZ_128:  return |lo;
      default: return 1'b1;
    endcase
  endfunction

  // patch a byte or halfword into a fetched word
  function automatic logic [31:0] merge_word(input logic [31:0] old,
                                             input logic [15:0] nd,
                                             input logic [2:0]  sz,
                                             input logic [1:0]  off);
    logic [31:0] r;
    r = old;
    if (sz == SZ_8) r[{off, 3'b000} +: 8] = nd[7:0];
    else            r[{off[1], 4'b0000} +: 16] = nd;
    return r;
  endfunction

  // bytes sent to the serial port for a given size
  function automatic logic [2:0] tx_count(input logic [2:0] sz);
    case (sz)
      SZ_8:    return 3'd1;
      SZ_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bwa_region_dec.sv
module bwa_region_dec #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_LSB   = 12,
  parameter int FIFO_PAGE0 = 4,
  parameter int NUM_FIFO   = 4,
  parameter int REG64_PAGE = 2,
  parameter int SPLIT_BIT  = 4,
  parameter logic [ADDR_W-1:0] TX_WORD_ADDR = 16'hF180,
  localparam int PAGE_W = ADDR_W - PAGE_LSB,
  localparam int PORT_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  output bwa_pkg::region_e     region,
  output logic [PORT_W-1:0]    port
);
  import bwa_pkg::*;

  localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_FIFO - 1);

  logic [PAGE_W-1:0] page;
  logic              in_fifo;
  logic              is_tx;

  assign page    = addr[ADDR_W-1:PAGE_LSB];
  assign is_tx   = (addr[ADDR_W-1:2] == TX_WORD_ADDR[ADDR_W-1:2]);
  assign in_fifo = ({1'b0, page} >= (PAGE_W+1)'(FIFO_PAGE0)) &&
                   ({1'b0, page} <  (PAGE_W+1)'(FIFO_PAGE0 + NUM_FIFO));

  always_comb begin
    region = RG_REG32;
    port   = '0;
    if (is_tx) begin
      region = RG_TX;
    end else if (in_fifo) begin
      port = PORT_W'(page - PAGE_W'(FIFO_PAGE0));
      if ((port == LAST_PORT) && !addr[SPLIT_BIT]) region = RG_FIFO_DROP;
      else                                          region = RG_FIFO;
    end else if (page == PAGE_W'(REG64_PAGE)) begin
      region = RG_REG64;
    end
  end

endmodule

// File: rtl/bwa_lane_fill.sv
module bwa_lane_fill #(
  parameter int BEAT_W = 128,
  localparam int NB    = BEAT_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [BEAT_W-1:0] data,
  input  logic [OFF_W-1:0]  off,
  input  logic [OFF_W:0]    nbytes,
  output logic [BEAT_W-1:0] beat
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [OFF_W:0] rel;
    logic           hit;
    assign rel = (OFF_W+1)'(b) - {1'b0, off};
    assign hit = ((OFF_W+1)'(b) >= {1'b0, off}) && (rel < nbytes);
    assign beat[8*b +: 8] = hit ? data[{rel[OFF_W-1:0], 3'b000} +: 8] : 8'h00;
  end

endmodule

// File: rtl/bwa_tx_ser.sv
module bwa_tx_ser #(
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(WORD_W / 8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_cnt,
  output logic              tx_wr,
  output logic [7:0]        tx_byte,
  output logic              active
);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      remain <= '0;
    end else if (load) begin
      shreg  <= load_word;
      remain <= load_cnt;
    end else if (remain != '0) begin
      shreg  <= shreg >> 8;
      remain <= remain - 1'b1;
    end
  end

  assign active  = (remain != '0);
  assign tx_wr   = active;
  assign tx_byte = shreg[7:0];

endmodule

// File: rtl/bwa_write_adapter.sv
module bwa_write_adapter #(
  parameter int ADDR_W     = 16,
  parameter int BEAT_W     = 128,
  parameter int PAGE_LSB   = 12,
  parameter int FIFO_PAGE0 = 4,
  parameter int NUM_FIFO   = 4,
  parameter int REG64_PAGE = 2,
  parameter int SPLIT_BIT  = 4,
  parameter logic [ADDR_W-1:0] TX_WORD_ADDR = 16'hF180,
  localparam int PORT_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1,
  localparam int REG_W  = BEAT_W / 4,
  localparam int R64_W  = BEAT_W / 2,
  localparam int OFF_W  = $clog2(BEAT_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [BEAT_W-1:0] req_wdata,
  output logic              busy,
  output logic              err,
  output logic              fifo_push,
  output logic [PORT_W-1:0] fifo_port,
  output logic [BEAT_W-1:0] fifo_data,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [REG_W-1:0]  reg_wdata,
  output logic              reg64_wr,
  output logic [ADDR_W-1:0] reg64_addr,
  output logic [R64_W-1:0]  reg64_wdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  rd_data,
  output logic              tx_wr,
  output logic [7:0]        tx_byte
);
  import bwa_pkg::*;

  // named internal events, observed by the checker
  logic accept;
  logic bad_align;
  logic go;
  logic narrow;
  logic drop_out;
  logic tx_load;
  logic tx_active;

  region_e            region;
  logic [PORT_W-1:0]  dec_port;
  logic [BEAT_W-1:0]  fill_beat;
  logic [ADDR_W-1:0]  word_addr;
  logic [ADDR_W-1:0]  dword_addr;

  logic               rmw_pend;
  logic [ADDR_W-1:0]  rmw_addr;
  logic [15:0]        rmw_data;
  logic [2:0]         rmw_size;
  logic [1:0]         rmw_off;

  bwa_region_dec #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .FIFO_PAGE0(FIFO_PAGE0),
    .NUM_FIFO(NUM_FIFO), .REG64_PAGE(REG64_PAGE), .SPLIT_BIT(SPLIT_BIT),
    .TX_WORD_ADDR(TX_WORD_ADDR)
  ) u_dec (
    .addr  (req_addr),
    .region(region),
    .port  (dec_port)
  );

  bwa_lane_fill #(.BEAT_W(BEAT_W)) u_fill (
    .data  (req_wdata),
    .off   (req_addr[OFF_W-1:0]),
    .nbytes((OFF_W+1)'(size_bytes(req_size))),
    .beat  (fill_beat)
  );

  bwa_tx_ser #(.WORD_W(REG_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_word(req_wdata[REG_W-1:0]),
    .load_cnt (tx_count(req_size)),
    .tx_wr    (tx_wr),
    .tx_byte  (tx_byte),
    .active   (tx_active)
  );

  assign busy       = rmw_pend | tx_active;
  assign accept     = req_valid & ~busy;
  assign bad_align  = misaligned(req_addr[3:0], req_size);
  assign go         = accept & ~bad_align;
  assign narrow     = (req_size == SZ_8) || (req_size == SZ_16);
  assign drop_out   = go && (region == RG_FIFO_DROP);
  assign tx_load    = go && (region == RG_TX);
  assign word_addr  = {req_addr[ADDR_W-1:2], 2'b00};
  assign dword_addr = {req_addr[ADDR_W-1:3], 3'b000};

  assign rd_req  = rmw_pend;
  assign rd_addr = rmw_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err         <= 1'b0;
      fifo_push   <= 1'b0;
      fifo_port   <= '0;
      fifo_data   <= '0;
      reg_wr      <= 1'b0;
      reg_addr    <= '0;
      reg_wdata   <= '0;
      reg64_wr    <= 1'b0;
      reg64_addr  <= '0;
      reg64_wdata <= '0;
      rmw_pend    <= 1'b0;
      rmw_addr    <= '0;
      rmw_data    <= '0;
      rmw_size    <= '0;
      rmw_off     <= '0;
    end else begin
      err      <= 1'b0;
      fifo_push <= 1'b0;
      reg_wr   <= 1'b0;
      reg64_wr <= 1'b0;

      // second half of a merge: write back the patched word
      if (rmw_pend) begin
        rmw_pend  <= 1'b0;
        reg_wr    <= 1'b1;
        reg_addr  <= rmw_addr;
        reg_wdata <= merge_word(rd_data, rmw_data, rmw_size, rmw_off);
      end

      if (accept && bad_align) err <= 1'b1;

      if (go) begin
        case (region)
          RG_FIFO: begin
            fifo_push <= 1'b1;
            fifo_port <= dec_port;
            fifo_data <= fill_beat;
          end
          RG_REG32, RG_REG64: begin
            if (narrow) begin
              rmw_pend <= 1'b1;
              rmw_addr <= word_addr;
              rmw_data <= req_wdata[15:0];
              rmw_size <= req_size;
              rmw_off  <= req_addr[1:0];
            end else if ((region == RG_REG64) && (req_size != SZ_32)) begin
              reg64_wr    <= 1'b1;
              reg64_addr  <= dword_addr;
              reg64_wdata <= req_wdata[R64_W-1:0];
            end else begin
              reg_wr    <= 1'b1;
              reg_addr  <= req_addr;
              reg_wdata <= req_wdata[REG_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/bwa_write_adapter_chk.sv
module bwa_write_adapter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_addr4,
  input logic       busy,
  input logic       err,
  input logic       fifo_push,
  input logic [1:0] fifo_port,
  input logic       reg_wr,
  input logic       reg64_wr,
  input logic [2:0] reg64_addr_lo,
  input logic       rd_req,
  input logic       tx_wr,
  input logic       drop_out
);

  assert_push_from_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $past(req_valid && !busy));

  assert_split_port_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && fifo_port == 2'd3) |-> $past(req_addr4));

  assert_drop_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_out |=> !(fifo_push || reg_wr || reg64_wr || err || rd_req || tx_wr));

  assert_reg64_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg64_wr |-> (reg64_addr_lo == 3'd0));

  assert_merge_writes_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (reg_wr && !rd_req));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(fifo_push || reg64_wr || err));

  assert_tx_holds_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> busy);

  assert_err_from_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid && !busy));

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_push, reg_wr, reg64_wr, err, rd_req, tx_wr}));

endmodule

bind bwa_write_adapter bwa_write_adapter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr4    (req_addr[4]),
  .busy         (busy),
  .err          (err),
  .fifo_push    (fifo_push),
  .fifo_port    (fifo_port),
  .reg_wr       (reg_wr),
  .reg64_wr     (reg64_wr),
  .reg64_addr_lo(reg64_addr[2:0]),
  .rd_req       (rd_req),
  .tx_wr        (tx_wr),
  .drop_out     (drop_out)
);

// File: tb/tb_bwa_write_adapter.sv
module tb_bwa_write_adapter;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [2:0]   req_size = '0;
  logic [127:0] req_wdata = '0;
  logic         busy, err, fifo_push, reg_wr, reg64_wr, rd_req, tx_wr;
  logic [1:0]   fifo_port;
  logic [127:0] fifo_data;
  logic [15:0]  reg_addr, reg64_addr, rd_addr;
  logic [31:0]  reg_wdata, rd_data;
  logic [63:0]  reg64_wdata;
  logic [7:0]   tx_byte;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  int idx  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] rdm(input logic [15:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  assign rd_data = rdm(rd_addr);

  bwa_write_adapter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .busy(busy), .err(err),
    .fifo_push(fifo_push), .fifo_port(fifo_port), .fifo_data(fifo_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg64_wr(reg64_wr), .reg64_addr(reg64_addr), .reg64_wdata(reg64_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_wr(tx_wr), .tx_byte(tx_byte)
  );

  function automatic logic [127:0] dgen(input int i);
    logic [31:0] u;
    u = 32'(i);
    return {u * 32'h9E3779B9 + 32'd1, u * 32'h7F4A7C15 + 32'd3,
            u * 32'h85EBCA6B + 32'd5, u * 32'hC2B2AE35 + 32'd7};
  endfunction

  // zero-filled beat, built byte by byte
  function automatic logic [127:0] bfill(input logic [127:0] d, input int sz, input int off);
    logic [127:0] r;
    int nb;
    r  = '0;
    nb = 1 << sz;
    for (int b = 0; b < 16; b++)
      if (b >= off && b < off + nb) r[b*8 +: 8] = d[(b-off)*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] bmerge(input logic [31:0] old, input logic [15:0] nd,
                                         input int sz, input int off);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) begin
      if (sz == 0 && b == off) r[b*8 +: 8] = nd[7:0];
      if (sz == 1 && (b / 2) == (off / 2)) r[b*8 +: 8] = nd[(b%2)*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // strobe pattern {fifo_push, reg_wr, reg64_wr, err, rd_req, tx_wr}
  task automatic chk_pat(input string tag, input logic [5:0] exp);
    chk(tag, 128'({fifo_push, reg_wr, reg64_wr, err, rd_req, tx_wr}), 128'(exp));
  endtask

  task automatic issue(input logic [15:0] a, input int sz, input logic [127:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = 3'(sz);
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [127:0] d;
    logic [15:0]  a;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk_pat("R11 strobes in reset", 6'b000000);
    chk("R11 busy in reset", 128'(busy), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pat("R11 strobes after reset", 6'b000000);
    chk("R11 busy after reset", 128'(busy), 128'(0));

    // R1 R2 R3 R4: FIFO pushes across ports, sizes and offsets
    for (int p = 0; p < 4; p++) begin
      for (int sz = 0; sz <= 4; sz++) begin
        for (int off = 0; off < 16; off += (1 << sz)) begin
          idx++;
          d = dgen(idx);
          a = 16'(((4 + p) << 12) | ((p == 3) ? 16 : 0) | off);
          issue(a, sz, d);
          chk_pat("R1 R2 R3 R4 fifo push strobe", 6'b100000);
          chk("R1 R4 fifo port", 128'(fifo_port), 128'(p));
          chk("R1 R2 R3 fifo beat", fifo_data, bfill(d, sz, off));
        end
      end
    end

    // R4: output side of the shared port drops everything
    for (int sz = 0; sz <= 4; sz++) begin
      idx++;
      issue(16'h7000, sz, dgen(idx));
      chk_pat("R4 dropped store silent", 6'b000000);
      @(negedge clk);
      chk_pat("R4 dropped store stays silent", 6'b000000);
    end

    // R5: 64-bit register page
    idx++; d = dgen(idx);
    issue(16'h2008, 3, d);
    chk_pat("R5 64-bit strobe", 6'b001000);
    chk("R5 64-bit addr", 128'(reg64_addr), 128'(16'h2008));
    chk("R5 64-bit data", 128'(reg64_wdata), 128'(d[63:0]));
    idx++; d = dgen(idx);
    issue(16'h2010, 4, d);
    chk_pat("R5 128-bit strobe", 6'b001000);
    chk("R5 128-bit addr", 128'(reg64_addr), 128'(16'h2010));
    chk("R5 128-bit low half", 128'(reg64_wdata), 128'(d[63:0]));
    idx++; d = dgen(idx);
    issue(16'h2004, 2, d);
    chk_pat("R5 32-bit strobe", 6'b010000);
    chk("R5 32-bit addr", 128'(reg_addr), 128'(16'h2004));
    chk("R5 32-bit data", 128'(reg_wdata), 128'(d[31:0]));

    // R6: ordinary registers, wide stores trimmed to 32 bits
    for (int sz = 2; sz <= 4; sz++) begin
      for (int pg = 0; pg < 16; pg++) begin
        if (pg == 2 || (pg >= 4 && pg <= 7) || pg == 15) continue;
        idx++; d = dgen(idx);
        a = 16'((pg << 12) | 16'h0040);
        issue(a, sz, d);
        chk_pat("R6 reg strobe", 6'b010000);
        chk("R6 reg addr", 128'(reg_addr), 128'(a));
        chk("R6 reg data", 128'(reg_wdata), 128'(d[31:0]));
      end
    end

    // R7: byte and halfword merges
    for (int sz = 0; sz <= 1; sz++) begin
      for (int off = 0; off < 4; off += (1 << sz)) begin
        for (int base = 0; base < 2; base++) begin
          idx++; d = dgen(idx);
          a = (base == 0) ? 16'h1100 : 16'h2200;
          issue(a | 16'(off), sz, d);
          chk_pat("R7 read cycle strobe", 6'b000010);
          chk("R7 read addr", 128'(rd_addr), 128'(a));
          chk("R8 busy in read cycle", 128'(busy), 128'(1));
          @(negedge clk);
          chk_pat("R7 write-back strobe", 6'b010000);
          chk("R7 write-back addr", 128'(reg_addr), 128'(a));
          chk("R7 merged word", 128'(reg_wdata), 128'(bmerge(rdm(a), d[15:0], sz, off)));
        end
      end
    end

    // R8: request held during merge read cycle is ignored
    idx++; d = dgen(idx);
    issue(16'h1304, 0, d);
    req_valid = 1'b1; req_addr = 16'h4000; req_size = 3'd4; req_wdata = dgen(idx + 1000);
    @(negedge clk);
    req_valid = 1'b0;
    chk_pat("R8 only write-back while blocked", 6'b010000);
    @(negedge clk);
    chk_pat("R8 blocked request left no push", 6'b000000);

    // R9: serial transmit port
    for (int sz = 0; sz <= 4; sz++) begin
      int n;
      idx++; d = dgen(idx);
      n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      a = (sz == 0) ? 16'hF183 : (sz == 1) ? 16'hF182 : 16'hF180;
      issue(a, sz, d);
      for (int k = 0; k < n; k++) begin
        chk_pat("R9 tx strobe", 6'b000001);
        chk("R9 tx byte order", 128'(tx_byte), 128'(d[k*8 +: 8]));
        chk("R9 busy while sending", 128'(busy), 128'(1));
        @(negedge clk);
      end
      chk_pat("R9 tx stream ended", 6'b000000);
      chk("R9 busy released", 128'(busy), 128'(0));
    end

    // R8 R9: request held through a byte stream is ignored
    idx++; d = dgen(idx);
    issue(16'hF180, 2, d);
    req_valid = 1'b1; req_addr = 16'h5000; req_size = 3'd4; req_wdata = dgen(idx + 2000);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk_pat("R8 stream not interrupted", 6'b000001);
      chk("R9 tx byte under pressure", 128'(tx_byte), 128'(d[k*8 +: 8]));
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk_pat("R8 held request dropped", 6'b000000);

    // R10: misaligned and illegal stores
    for (int sz = 1; sz <= 4; sz++) begin
      for (int off = 1; off < 16; off++) begin
        if (off % (1 << sz) == 0) continue;
        idx++;
        issue(16'h1200 | 16'(off), sz, dgen(idx));
        chk_pat("R10 misaligned refused", 6'b000100);
        @(negedge clk);
        chk_pat("R10 nothing after refusal", 6'b000000);
      end
    end
    issue(16'h4002, 2, dgen(idx));
    chk_pat("R10 misaligned fifo store refused", 6'b000100);
    for (int sz = 5; sz <= 7; sz++) begin
      issue(16'h1000, sz, dgen(sz));
      chk_pat("R10 illegal size refused", 6'b000100);
    end

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule